// File: doc/BRIEF.md
# Flash Command-Completion Interrupt Status Register

This block keeps a 16-bit status word that tells the host which kind of internal flash operation has just finished. Four source flags cover the load, program, erase and reset families of commands. A master flag collects them, and it also collects a few housekeeping commands that have no flag of their own. The master flag drives an interrupt pin, and a polarity input selects whether that pin is active high or active low.

The command sequencer reports a finished operation by pulsing `done_vld` for one cycle together with the 16-bit command code. It reports a finished buffer fill on `buf_load_done` and a finished boot load on `boot_done`. A flag is set only by hardware. The host clears a flag by writing a zero to its bit. The register starts from a different value after a cold reset than after a warm reset, and the reset-source flag is kept across a warm reset. Every effect appears on `host_rd_data` one clock after the edge that samples it.

Top module: `flash_irq_status`

## Requirements
- R1: Only bit 15 (master), bit 7 (load), bit 6 (program), bit 5 (erase) and bit 4 (reset source) can be one; every other bit of `host_rd_data` always reads zero.
- R2: `rst_n` low or `cold_rst_req` high at an edge loads 8080h: the master and load flags are set and all other bits, the reset-source flag included, are cleared.
- R3: While `warm_rst_req` is high, the master, load, program and erase flags are held at zero and the reset-source flag keeps its value. On the first edge at which `warm_rst_req` is seen low after being high, the reset-source and master flags are set, which gives 8010h from a clean state.
- R4: A completion with code 0000h or 0013h, or a `boot_done` pulse, sets the load flag (bit 7) and the master flag.
- R5: A completion with code 0080h, 001Ah or 001Bh sets the program flag (bit 6) and the master flag.
- R6: A completion with code 0030h, 0094h or 0095h sets the erase flag (bit 5) and the master flag.
- R7: A completion with code 00B0h, 00F0h or 00F3h sets the reset-source flag (bit 4) and the master flag.
- R8: A completion with code 0023h, 002Ah, 002Ch, 0065h or 0071h, or a `buf_load_done` pulse, sets only the master flag.
- R9: A host write clears each of bits 15, 7, 6, 5 and 4 whose written bit is zero. A written one leaves that bit unchanged, so the host can never set a flag.
- R10: When a hardware set and a host clear hit the same bit in the same cycle, the bit ends up set.
- R11: A completion whose code is not listed in R4 to R8, and any code presented while `done_vld` is low, leaves the register unchanged.
- R12: With `int_pol` high, `int_pin` equals the master flag. With `int_pol` low, `int_pin` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset (acts as a cold reset) |
| cold_rst_req | input | 1 | Cold reset request, sampled each edge |
| warm_rst_req | input | 1 | Warm/hot reset request level; its release sets the reset-source flag |
| boot_done | input | 1 | One-cycle pulse when the boot load has finished |
| done_vld | input | 1 | One-cycle strobe that qualifies `done_code` |
| done_code | input | 16 | Command code of the operation that just finished |
| buf_load_done | input | 1 | One-cycle pulse when a buffer load has finished |
| host_wr_en | input | 1 | Host register write enable |
| host_wr_data | input | 16 | Host write data; a zero clears the matching flag |
| host_rd_data | output | 16 | Current register contents |
| int_pol | input | 1 | Interrupt pin polarity, 1 = active high |
| int_pin | output | 1 | Interrupt pin |

## Verification
Two events can reach the same bit in one cycle: a hardware completion that sets a flag, and a host write that clears it. The bench drives the program code 0080h together with an all-zero write in a single cycle, then expects the program flag and the master flag to read as one. A second overlap comes from the warm-reset release edge, where the reset-source flag must be set while the other flags stay at zero from the hold. The bench checks that the resulting word is exactly 8010h, and that a reset-source flag set before the warm reset is still present after it.

// File: rtl/fis_pkg.sv
// Package: shared constants and types for the flash interrupt status block.
// Assumes a 16-bit register and 16-bit command codes.
package fis_pkg;

    localparam int unsigned REG_W    = 16;
    localparam int unsigned CODE_W   = 16;
    localparam int unsigned N_SRC    = 4;
    localparam int unsigned MST_POS  = 15;

    // Source flag positions: load, program, erase, reset-source.
    localparam int unsigned SRC_POS      [N_SRC] = '{7, 6, 5, 4};
    // Value each source flag takes on a cold reset.
    localparam bit          SRC_COLD_VAL [N_SRC] = '{1'b1, 1'b0, 1'b0, 1'b0};
    // Whether a warm reset clears each source flag.
    localparam bit          SRC_WARM_CLR [N_SRC] = '{1'b1, 1'b1, 1'b1, 1'b0};

    localparam int unsigned IDX_LOAD  = 0;
    localparam int unsigned IDX_PROG  = 1;
    localparam int unsigned IDX_ERASE = 2;
    localparam int unsigned IDX_RST   = 3;

    // Command codes, by family.
    localparam logic [CODE_W-1:0] CMD_LOAD_MAIN  = 16'h0000;
    localparam logic [CODE_W-1:0] CMD_LOAD_ALT   = 16'h0013;
    localparam logic [CODE_W-1:0] CMD_PROG_MAIN  = 16'h0080;
    localparam logic [CODE_W-1:0] CMD_PROG_ALT_A = 16'h001A;
    localparam logic [CODE_W-1:0] CMD_PROG_ALT_B = 16'h001B;
    localparam logic [CODE_W-1:0] CMD_ERA_SINGLE = 16'h0094;
    localparam logic [CODE_W-1:0] CMD_ERA_MULTI  = 16'h0095;
    localparam logic [CODE_W-1:0] CMD_ERA_CONF   = 16'h0030;
    localparam logic [CODE_W-1:0] CMD_RST_CORE   = 16'h00B0;
    localparam logic [CODE_W-1:0] CMD_RST_HOT    = 16'h00F0;
    localparam logic [CODE_W-1:0] CMD_RST_ARRAY  = 16'h00F3;
    localparam logic [CODE_W-1:0] CMD_UNPROT     = 16'h0023;
    localparam logic [CODE_W-1:0] CMD_PROT       = 16'h002A;
    localparam logic [CODE_W-1:0] CMD_PROT_FIX   = 16'h002C;
    localparam logic [CODE_W-1:0] CMD_ERA_CHECK  = 16'h0071;
    localparam logic [CODE_W-1:0] CMD_OTP        = 16'h0065;

    // Result of decoding one completion.
    typedef struct packed {
        logic load;
        logic prog;
        logic erase;
        logic rst;
        logic mst_only;
    } cmd_class_t;

endpackage

// File: rtl/fis_cmd_classify.sv
// Module: fis_cmd_classify
// Maps a qualified completion code to its command family.
// Assumes done_vld is a one-cycle strobe. An unknown code gives all zeros.
module fis_cmd_classify
    import fis_pkg::*;
(
    input  logic              done_vld,
    input  logic [CODE_W-1:0] done_code,
    output cmd_class_t        cls
);

    // Decode the code into exactly one family, or none.
    always_comb begin
        cls = '0;
        if (done_vld) begin
            case (done_code)
                CMD_LOAD_MAIN, CMD_LOAD_ALT:                  cls.load     = 1'b1;
                CMD_PROG_MAIN, CMD_PROG_ALT_A, CMD_PROG_ALT_B: cls.prog     = 1'b1;
                CMD_ERA_SINGLE, CMD_ERA_MULTI, CMD_ERA_CONF:  cls.erase    = 1'b1;
                CMD_RST_CORE, CMD_RST_HOT, CMD_RST_ARRAY:     cls.rst      = 1'b1;
                CMD_UNPROT, CMD_PROT, CMD_PROT_FIX,
                CMD_ERA_CHECK, CMD_OTP:                       cls.mst_only = 1'b1;
                default:                                      cls          = '0;
            endcase
        end
    end

endmodule

// File: rtl/fis_flag_bit.sv
// Module: fis_flag_bit
// One sticky status flag. Hardware sets it, the host clears it.
// Priority, highest first: cold reset, warm hold (when the flag is warm-cleared),
// hardware set, host clear. Set beats clear so that no completion is lost.
module fis_flag_bit #(
    parameter bit COLD_VAL    = 1'b0,
    parameter bit CLR_ON_WARM = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cold_req,
    input  logic warm_hold,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    // Flag state update with reset-type dependent value.
    always_ff @(posedge clk) begin
        if (!rst_n || cold_req) begin
            q <= COLD_VAL;
        end else if (warm_hold && CLR_ON_WARM) begin
            q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end else if (clr_i) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/fis_pin_drive.sv
// Module: fis_pin_drive
// Applies the selected polarity to the master flag to drive the interrupt pin.
// Combinational, so a polarity change shows on the pin at once.
module fis_pin_drive (
    input  logic mst_flag,
    input  logic pol_high,
    output logic pin
);

    // Pass the flag through when active high, invert it when active low.
    always_comb begin
        pin = pol_high ? mst_flag : ~mst_flag;
    end

endmodule

// File: rtl/flash_irq_status.sv
// Module: flash_irq_status (top)
// Interrupt status register for a flash controller: four source flags and a
// master flag, reset values that depend on the reset type, and a polarity-
// selectable interrupt pin. Assumes every strobe input is one cycle wide and
// synchronous to clk, and that warm_rst_req is a level.
module flash_irq_status
    import fis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cold_rst_req,
    input  logic              warm_rst_req,
    input  logic              boot_done,
    input  logic              done_vld,
    input  logic [CODE_W-1:0] done_code,
    input  logic              buf_load_done,
    input  logic              host_wr_en,
    input  logic [REG_W-1:0]  host_wr_data,
    output logic [REG_W-1:0]  host_rd_data,
    input  logic              int_pol,
    output logic              int_pin
);

    cmd_class_t       cls;
    logic             warm_q;
    logic             warm_release;
    logic [N_SRC-1:0] src_set;
    logic [N_SRC-1:0] src_clr;
    logic [N_SRC-1:0] src_q;
    logic             mst_set;
    logic             mst_clr;
    logic             mst_q;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^{host_wr_data[14:8], host_wr_data[3:0]};

    fis_cmd_classify u_classify (
        .done_vld  (done_vld),
        .done_code (done_code),
        .cls       (cls)
    );

    // Remember the warm reset level so that its release can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n || cold_rst_req) begin
            warm_q <= 1'b0;
        end else begin
            warm_q <= warm_rst_req;
        end
    end

    assign warm_release = warm_q && !warm_rst_req;

    // Gather the hardware set events for each source flag.
    always_comb begin
        src_set            = '0;
        src_set[IDX_LOAD]  = cls.load | boot_done;
        src_set[IDX_PROG]  = cls.prog;
        src_set[IDX_ERASE] = cls.erase;
        src_set[IDX_RST]   = cls.rst | warm_release;
    end

    // The master flag also collects the families that have no flag of their own.
    assign mst_set = (|src_set) | cls.mst_only | buf_load_done;
    assign mst_clr = host_wr_en && !host_wr_data[MST_POS];

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign src_clr[i] = host_wr_en && !host_wr_data[SRC_POS[i]];

        fis_flag_bit #(
            .COLD_VAL    (SRC_COLD_VAL[i]),
            .CLR_ON_WARM (SRC_WARM_CLR[i])
        ) u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .cold_req  (cold_rst_req),
            .warm_hold (warm_rst_req),
            .set_i     (src_set[i]),
            .clr_i     (src_clr[i]),
            .q         (src_q[i])
        );
    end

    fis_flag_bit #(
        .COLD_VAL    (1'b1),
        .CLR_ON_WARM (1'b1)
    ) u_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .cold_req  (cold_rst_req),
        .warm_hold (warm_rst_req),
        .set_i     (mst_set),
        .clr_i     (mst_clr),
        .q         (mst_q)
    );

    // Place the flags at their bit positions; reserved bits stay zero.
    always_comb begin
        host_rd_data          = '0;
        host_rd_data[MST_POS] = mst_q;
        for (int i = 0; i < N_SRC; i++) begin
            host_rd_data[SRC_POS[i]] = src_q[i];
        end
    end

    fis_pin_drive u_pin (
        .mst_flag (mst_q),
        .pol_high (int_pol),
        .pin      (int_pin)
    );

endmodule

// File: rtl/fis_checker.sv
// Module: fis_checker
// Property checks for flash_irq_status, attached to it by bind.
module fis_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cold_rst_req,
    input logic        warm_rst_req,
    input logic        boot_done,
    input logic        done_vld,
    input logic [15:0] done_code,
    input logic        buf_load_done,
    input logic        host_wr_en,
    input logic [15:0] host_wr_data,
    input logic [15:0] host_rd_data,
    input logic        int_pol,
    input logic        int_pin
);

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_data & 16'h7F0F) == 16'h0000);

    a_r2_cold_value: assert property (@(posedge clk) disable iff (!rst_n)
        cold_rst_req |=> host_rd_data == 16'h8080);

    a_r3_warm_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(warm_rst_req) && !cold_rst_req) |=> (host_rd_data[4] && host_rd_data[15]));

    a_r9_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && !done_vld && !buf_load_done && !boot_done && !cold_rst_req
         && !warm_rst_req && !$fell(warm_rst_req))
        |=> (host_rd_data & ~$past(host_rd_data)) == 16'h0000);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && done_code == 16'h0080 && host_wr_en && !host_wr_data[6]
         && !cold_rst_req && !warm_rst_req) |=> host_rd_data[6]);

    a_r12_pin_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        int_pin == (int_pol ? host_rd_data[15] : !host_rd_data[15]));

endmodule

bind flash_irq_status fis_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cold_rst_req  (cold_rst_req),
    .warm_rst_req  (warm_rst_req),
    .boot_done     (boot_done),
    .done_vld      (done_vld),
    .done_code     (done_code),
    .buf_load_done (buf_load_done),
    .host_wr_en    (host_wr_en),
    .host_wr_data  (host_wr_data),
    .host_rd_data  (host_rd_data),
    .int_pol       (int_pol),
    .int_pin       (int_pin)
);

// File: tb/flash_irq_status_tb.sv
// Scoreboard bench: the driver pushes the expected word and pin for each cycle,
// and the monitor pops and compares them at the following falling edge.
module flash_irq_status_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cold_rst_req;
    logic        warm_rst_req;
    logic        boot_done;
    logic        done_vld;
    logic [15:0] done_code;
    logic        buf_load_done;
    logic        host_wr_en;
    logic [15:0] host_wr_data;
    logic [15:0] host_rd_data;
    logic        int_pol;
    logic        int_pin;

    typedef struct {
        logic [15:0] data;
        logic        pin;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #2 clk = ~clk;

    flash_irq_status u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cold_rst_req  (cold_rst_req),
        .warm_rst_req  (warm_rst_req),
        .boot_done     (boot_done),
        .done_vld      (done_vld),
        .done_code     (done_code),
        .buf_load_done (buf_load_done),
        .host_wr_en    (host_wr_en),
        .host_wr_data  (host_wr_data),
        .host_rd_data  (host_rd_data),
        .int_pol       (int_pol),
        .int_pin       (int_pin)
    );

    // Monitor: compare the oldest expected item with the design outputs.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (host_rd_data !== e.data) begin
                n_fail++;
                $display("FAIL %s data actual=%h expected=%h", e.tag, host_rd_data, e.data);
            end
            n_checks++;
            if (int_pin !== e.pin) begin
                n_fail++;
                $display("FAIL %s pin actual=%b expected=%b", e.tag, int_pin, e.pin);
            end
        end
    end

    // Return the one-cycle inputs to their idle values.
    task automatic idle();
        cold_rst_req  = 1'b0;
        boot_done     = 1'b0;
        done_vld      = 1'b0;
        done_code     = 16'h5A5A;
        buf_load_done = 1'b0;
        host_wr_en    = 1'b0;
        host_wr_data  = 16'h0000;
    endtask

    // Driver: run one cycle with the current inputs and push the expectation.
    // The pin expectation follows R12 from the expected master flag.
    task automatic cyc(input logic [15:0] exp_data, input string tag);
        exp_t e;
        @(posedge clk);
        e.data = exp_data;
        e.pin  = int_pol ? exp_data[15] : ~exp_data[15];
        e.tag  = tag;
        sb_q.push_back(e);
        @(negedge clk);
        #1;
        idle();
    endtask

    task automatic cmd(input logic [15:0] code, input logic [15:0] exp_data, input string tag);
        done_vld  = 1'b1;
        done_code = code;
        cyc(exp_data, tag);
    endtask

    task automatic wr(input logic [15:0] d, input logic [15:0] exp_data, input string tag);
        host_wr_en   = 1'b1;
        host_wr_data = d;
        cyc(exp_data, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        warm_rst_req = 1'b0;
        int_pol      = 1'b1;
        #1;
        idle();
        cyc(16'h8080, "R2 power-on reset");
        cyc(16'h8080, "R2 power-on reset held");
        rst_n = 1'b1;
        cyc(16'h8080, "R1 idle after reset");

        wr(16'h0000, 16'h0000, "R9 clear all");
        cmd(16'h0013, 16'h8080, "R4 load alt code");
        wr(16'hFF7F, 16'h8000, "R9 clear load only");
        wr(16'hFFFF, 16'h8000, "R9 write ones no effect");
        wr(16'h0000, 16'h0000, "R9 clear master");
        cmd(16'h0000, 16'h8080, "R4 load main code");
        wr(16'h0000, 16'h0000, "R9 clear");

        cmd(16'h001A, 16'h8040, "R5 program code");
        cmd(16'h0095, 16'h8060, "R6 erase code");
        cmd(16'h00F3, 16'h8070, "R7 reset code");
        wr(16'h7FFF, 16'h0070, "R9 clear master keeps sources");
        cmd(16'h001B, 16'h8070, "R5 program alt code");
        wr(16'h0000, 16'h0000, "R9 clear");

        cmd(16'h002C, 16'h8000, "R8 protect-fix code");
        wr(16'h0000, 16'h0000, "R9 clear");
        cmd(16'h0065, 16'h8000, "R8 otp code");
        wr(16'h0000, 16'h0000, "R9 clear");
        buf_load_done = 1'b1;
        cyc(16'h8000, "R8 buffer load done");
        wr(16'h0000, 16'h0000, "R9 clear");

        cmd(16'h1234, 16'h0000, "R11 unlisted code");
        done_code = 16'h0071;
        cyc(16'h0000, "R11 code without strobe");

        done_vld     = 1'b1;
        done_code    = 16'h0080;
        host_wr_en   = 1'b1;
        host_wr_data = 16'h0000;
        cyc(16'h8040, "R10 set beats clear");

        int_pol = 1'b0;
        cyc(16'h8040, "R12 active-low pin with master set");
        wr(16'h0000, 16'h0000, "R12 active-low pin with master clear");
        int_pol = 1'b1;
        cyc(16'h0000, "R12 active-high pin with master clear");

        cmd(16'h0030, 16'h8020, "R6 erase conf code");
        warm_rst_req = 1'b1;
        cyc(16'h0000, "R3 warm hold clears");
        cyc(16'h0000, "R3 warm hold steady");
        warm_rst_req = 1'b0;
        cyc(16'h8010, "R3 warm release");
        cyc(16'h8010, "R3 after release stable");

        cold_rst_req = 1'b1;
        cyc(16'h8080, "R2 cold request");
        wr(16'h0000, 16'h0000, "R9 clear");

        cmd(16'h00B0, 16'h8010, "R7 core reset code");
        cmd(16'h0094, 16'h8030, "R6 erase single code");
        warm_rst_req = 1'b1;
        cyc(16'h0010, "R3 reset-source kept in warm hold");
        warm_rst_req = 1'b0;
        cyc(16'h8010, "R3 release after kept flag");
        boot_done = 1'b1;
        cyc(16'h8090, "R4 boot done");
        cmd(16'h002A, 16'h8090, "R8 protect code");
        cmd(16'h00F0, 16'h8090, "R7 hot reset code");
        cyc(16'h8090, "R1 final idle");

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule